// File: doc/BRIEF.md
# Integer ALU with Two-Level Operation Decode

This block is the arithmetic and logic unit of a simple load/store processor datapath, together with the small decoder that selects its operation. The decoder turns a 2-bit operation class from the main control unit and the 6-bit function field of a register-format instruction into a 4-bit control code. The datapath then produces a bitwise AND, OR or NOR, a sum, a difference, or a less-than flag from two operands.

Add, subtract and less-than all share one ripple-carry adder. Subtraction feeds the inverted second operand and a carry-in of one. Less-than takes the sign bit of that difference. The block also reports a zero flag and a signed overflow flag. Overflow is the carry entering the top bit XOR the carry leaving it. An unsigned-mode input masks it. The whole block is combinational.

Top module: `alu_core`

## Requirements
- R1: Operation class 00 decodes to add (control 0010) and class 01 to subtract (control 0110), whatever the function field holds.
- R2: With operation class 10 the function field selects: 0x20 add (0010), 0x22 subtract (0110), 0x24 AND (0000), 0x25 OR (0001), 0x2A less-than (0111).
- R3: With operation class 10, any other function value gives control 1111. Any control code outside {0000, 0001, 0010, 0110, 0111, 1100} makes the result 0 with overflow 0.
- R4: Add returns (a + b) modulo 2^DATA_W.
- R5: Subtract returns a + ~b + 1 modulo 2^DATA_W.
- R6: Less-than returns the top bit of the difference a - b in result bit 0, with every other result bit 0.
- R7: Controls 0000, 0001 and 1100 return the bitwise AND, OR and NOR of the operands.
- R8: The zero output is 1 exactly when every result bit is 0.
- R9: For add and subtract, overflow equals the carry into the top bit XOR the carry out of it. It is 0 whenever unsigned_mode is 1.
- R10: Overflow is 0 for AND, OR, NOR and less-than.
- R11: Operation class 11 passes function bits [3:0] straight through as the control code, so NOR and the reserved codes can be selected directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | DATA_W | First operand |
| op_b | input | DATA_W | Second operand |
| alu_op | input | 2 | Operation class from the main control unit |
| funct | input | 6 | Function field of the instruction |
| unsigned_mode | input | 1 | 1 masks the overflow flag |
| result | output | DATA_W | Operation result |
| zero | output | 1 | 1 when the result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| alu_ctl | output | 4 | Decoded control code |

## Verification
The bench builds the block with its default DATA_W of 32. This puts the sign boundary at bit 31, so the most-positive and most-negative words can be used as stimulus.

With those words the bench drives add and subtract across the signed boundary, where the carry into bit 31 and the carry out of it differ. It checks a less-than case whose difference wraps, where the sign bit gives 1 even though the signed order says otherwise. It also checks an all-ones plus one sum that carries out without overflowing.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int CTL_W   = 4;
    localparam int OPC_W   = 2;
    localparam int FUNCT_W = 6;

    typedef logic [CTL_W-1:0]   ctl_t;
    typedef logic [OPC_W-1:0]   opc_t;
    typedef logic [FUNCT_W-1:0] funct_t;

    localparam ctl_t CTL_AND  = 4'b0000;
    localparam ctl_t CTL_OR   = 4'b0001;
    localparam ctl_t CTL_ADD  = 4'b0010;
    localparam ctl_t CTL_SUB  = 4'b0110;
    localparam ctl_t CTL_SLT  = 4'b0111;
    localparam ctl_t CTL_NOR  = 4'b1100;
    localparam ctl_t CTL_NONE = 4'b1111;

    localparam opc_t OPC_MEM    = 2'b00;
    localparam opc_t OPC_BRANCH = 2'b01;
    localparam opc_t OPC_RTYPE  = 2'b10;
    localparam opc_t OPC_DIRECT = 2'b11;

    localparam funct_t FN_ADD = 6'h20;
    localparam funct_t FN_SUB = 6'h22;
    localparam funct_t FN_AND = 6'h24;
    localparam funct_t FN_OR  = 6'h25;
    localparam funct_t FN_SLT = 6'h2A;

    function automatic ctl_t decode_rtype(input funct_t fn);
        case (fn)
            FN_ADD:  return CTL_ADD;
            FN_SUB:  return CTL_SUB;
            FN_AND:  return CTL_AND;
            FN_OR:   return CTL_OR;
            FN_SLT:  return CTL_SLT;
            default: return CTL_NONE;
        endcase
    endfunction

    function automatic logic ctl_uses_diff(input ctl_t c);
        return (c == CTL_SUB) || (c == CTL_SLT);
    endfunction

    function automatic logic ctl_is_arith(input ctl_t c);
        return (c == CTL_ADD) || (c == CTL_SUB);
    endfunction

endpackage

// File: rtl/alu_ctl_decode.sv
module alu_ctl_decode
    import alu_pkg::*;
(
    input  opc_t   alu_op,
    input  funct_t funct,
    output ctl_t   ctl
);
    always_comb begin
        unique case (alu_op)
            OPC_MEM:    ctl = CTL_ADD;
            OPC_BRANCH: ctl = CTL_SUB;
            OPC_RTYPE:  ctl = decode_rtype(funct);
            default:    ctl = funct[CTL_W-1:0];
        endcase
    end
endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_y,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              carry_msb_in,
    output logic              carry_out
);
    logic [DATA_W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < DATA_W; i++) begin : g_cell
        assign sum[i]       = in_x[i] ^ in_y[i] ^ chain[i];
        assign chain[i+1]   = (in_x[i] & in_y[i]) | (in_x[i] & chain[i]) | (in_y[i] & chain[i]);
    end

    assign carry_msb_in = chain[DATA_W-1];
    assign carry_out    = chain[DATA_W];
endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_x,
    input  logic [DATA_W-1:0] in_y,
    output logic [DATA_W-1:0] and_out,
    output logic [DATA_W-1:0] or_out,
    output logic [DATA_W-1:0] nor_out
);
    always_comb begin
        and_out = in_x & in_y;
        or_out  = in_x | in_y;
        nor_out = ~or_out;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [1:0]        alu_op,
    input  logic [5:0]        funct,
    input  logic              unsigned_mode,
    output logic [DATA_W-1:0] result,
    output logic              zero,
    output logic              overflow,
    output logic [3:0]        alu_ctl
);
    localparam int MSB = DATA_W - 1;

    ctl_t              ctl;
    logic              use_diff;
    logic [DATA_W-1:0] y_in;
    logic [DATA_W-1:0] sum;
    logic              c_msb_in;
    logic              c_out;
    logic [DATA_W-1:0] and_v, or_v, nor_v;

    alu_ctl_decode u_dec (
        .alu_op (alu_op),
        .funct  (funct),
        .ctl    (ctl)
    );

    assign use_diff = ctl_uses_diff(ctl);
    assign y_in     = op_b ^ {DATA_W{use_diff}};

    alu_ripple_adder #(.DATA_W(DATA_W)) u_add (
        .in_x         (op_a),
        .in_y         (y_in),
        .cin          (use_diff),
        .sum          (sum),
        .carry_msb_in (c_msb_in),
        .carry_out    (c_out)
    );

    alu_logic_unit #(.DATA_W(DATA_W)) u_log (
        .in_x    (op_a),
        .in_y    (op_b),
        .and_out (and_v),
        .or_out  (or_v),
        .nor_out (nor_v)
    );

    always_comb begin
        case (ctl)
            CTL_AND: result = and_v;
            CTL_OR:  result = or_v;
            CTL_NOR: result = nor_v;
            CTL_ADD,
            CTL_SUB: result = sum;
            CTL_SLT: result = {{(DATA_W-1){1'b0}}, sum[MSB]};
            default: result = '0;
        endcase
    end

    assign zero     = ~|result;
    assign overflow = ctl_is_arith(ctl) & ~unsigned_mode & (c_msb_in ^ c_out);
    assign alu_ctl  = ctl;
endmodule

// File: rtl/alu_core_checker.sv
module alu_core_checker
    import alu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic [DATA_W-1:0] result,
    input logic              zero,
    input logic              overflow,
    input logic [3:0]        alu_ctl,
    input logic [1:0]        alu_op,
    input logic [5:0]        funct,
    input logic              unsigned_mode
);
    logic known;
    logic defined_ctl;

    assign known = !$isunknown({result, zero, overflow, alu_ctl, alu_op, funct, unsigned_mode});
    assign defined_ctl = (alu_ctl == CTL_AND) || (alu_ctl == CTL_OR) || (alu_ctl == CTL_ADD) ||
                         (alu_ctl == CTL_SUB) || (alu_ctl == CTL_SLT) || (alu_ctl == CTL_NOR);

    always_comb begin
        if (known) begin
            p_fixed_class_r1: assert (alu_op[1] || alu_ctl == (alu_op[0] ? CTL_SUB : CTL_ADD))
                else $error("fixed class decode wrong");
            p_direct_pass_r11: assert (alu_op != OPC_DIRECT || alu_ctl == funct[3:0])
                else $error("direct class code not passed through");
            p_undef_zero_r3: assert (defined_ctl || (result == '0 && !overflow))
                else $error("undefined code produced output");
            p_slt_upper_r6: assert (alu_ctl != CTL_SLT || result[DATA_W-1:1] == '0)
                else $error("less-than upper bits set");
            p_zero_flag_r8: assert (zero == (result == '0))
                else $error("zero flag mismatch");
            p_no_overflow_r9: assert (!unsigned_mode || !overflow)
                else $error("overflow in unsigned mode");
            p_no_overflow_r10: assert (alu_ctl == CTL_ADD || alu_ctl == CTL_SUB || !overflow)
                else $error("overflow on non-arithmetic op");
        end
    end
endmodule

bind alu_core alu_core_checker #(.DATA_W(DATA_W)) u_chk (
    .result        (result),
    .zero          (zero),
    .overflow      (overflow),
    .alu_ctl       (alu_ctl),
    .alu_op        (alu_op),
    .funct         (funct),
    .unsigned_mode (unsigned_mode)
);

// File: tb/alu_core_test.sv
module alu_core_test;
    localparam int W = 32;

    typedef struct packed {
        logic [1:0]   op;
        logic [5:0]   fn;
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         uns;
        logic [3:0]   exp_ctl;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 6'h3F, 32'd5,          32'd7,          1'b0, 4'b0010},
        '{2'b00, 6'h22, 32'hFFFF_FFFF,  32'd1,          1'b0, 4'b0010},
        '{2'b01, 6'h20, 32'd10,         32'd3,          1'b0, 4'b0110},
        '{2'b10, 6'h20, 32'h7FFF_FFFF,  32'd1,          1'b0, 4'b0010},
        '{2'b10, 6'h20, 32'h7FFF_FFFF,  32'd1,          1'b1, 4'b0010},
        '{2'b10, 6'h22, 32'h8000_0000,  32'd1,          1'b0, 4'b0110},
        '{2'b10, 6'h22, 32'h8000_0000,  32'd1,          1'b1, 4'b0110},
        '{2'b10, 6'h22, 32'h0000_1234,  32'h0000_1234,  1'b0, 4'b0110},
        '{2'b10, 6'h24, 32'hF0F0_F0F0,  32'hFF00_FF00,  1'b0, 4'b0000},
        '{2'b10, 6'h25, 32'hF0F0_F0F0,  32'hFF00_FF00,  1'b0, 4'b0001},
        '{2'b10, 6'h2A, 32'd3,          32'd5,          1'b0, 4'b0111},
        '{2'b10, 6'h2A, 32'd5,          32'd3,          1'b0, 4'b0111},
        '{2'b10, 6'h2A, 32'h7FFF_FFFF,  32'hFFFF_FFFF,  1'b0, 4'b0111},
        '{2'b10, 6'h27, 32'h1234_5678,  32'h0F0F_0F0F,  1'b0, 4'b1111},
        '{2'b11, 6'h0C, 32'hF0F0_F0F0,  32'hFF00_FF00,  1'b0, 4'b1100},
        '{2'b11, 6'h05, 32'hAAAA_AAAA,  32'h5555_5555,  1'b0, 4'b0101},
        '{2'b11, 6'h02, 32'h8000_0000,  32'h8000_0000,  1'b0, 4'b0010},
        '{2'b11, 6'h07, 32'h8000_0000,  32'd1,          1'b0, 4'b0111}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [W-1:0] op_a = '0, op_b = '0;
    logic [1:0]   alu_op = '0;
    logic [5:0]   funct = '0;
    logic         unsigned_mode = 1'b0;
    logic [W-1:0] result;
    logic         zero, overflow;
    logic [3:0]   alu_ctl;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #10 clk = ~clk;

    alu_core #(.DATA_W(W)) uut (
        .op_a (op_a), .op_b (op_b), .alu_op (alu_op), .funct (funct),
        .unsigned_mode (unsigned_mode), .result (result), .zero (zero),
        .overflow (overflow), .alu_ctl (alu_ctl)
    );

    function automatic string req_of(input logic [3:0] c);
        case (c)
            4'b0010: return "R4";
            4'b0110: return "R5";
            4'b0111: return "R6";
            4'b0000, 4'b0001, 4'b1100: return "R7";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [W:0] model(input logic [3:0] c, input logic [W-1:0] a,
                                         input logic [W-1:0] b, input logic uns);
        logic [W-1:0] r;
        logic v;
        v = 1'b0;
        case (c)
            4'b0000: r = a & b;
            4'b0001: r = a | b;
            4'b1100: r = ~(a | b);
            4'b0010: begin
                r = a + b;
                v = (a[W-1] == b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b0110: begin
                r = a - b;
                v = (a[W-1] != b[W-1]) && (r[W-1] != a[W-1]);
            end
            4'b0111: begin
                r = a - b;
                r = {{(W-1){1'b0}}, r[W-1]};
            end
            default: r = '0;
        endcase
        if (uns) v = 1'b0;
        return {v, r};
    endfunction

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [5:0] fn, input logic [W-1:0] a,
                         input logic [W-1:0] b, input logic uns);
        @(negedge clk);
        alu_op = op; funct = fn; op_a = a; op_b = b; unsigned_mode = uns;
        #5;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [W:0] m;
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // Idle state: class 00, all-zero operands gives sum 0, zero set (R1, R8)
        apply(2'b00, 6'h00, '0, '0, 1'b0);
        check("R1", "idle ctl", {28'd0, alu_ctl}, {28'd0, 4'b0010});
        check("R8", "idle zero", {31'd0, zero}, 32'd1);
        check("R9", "idle overflow", {31'd0, overflow}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].uns);
            m = model(VECS[i].exp_ctl, VECS[i].a, VECS[i].b, VECS[i].uns);
            check(VECS[i].op == 2'b11 ? "R11" : (VECS[i].op == 2'b10 ? "R2" : "R1"),
                  "ctl", {28'd0, alu_ctl}, {28'd0, VECS[i].exp_ctl});
            check(req_of(VECS[i].exp_ctl), "result", result, m[W-1:0]);
            check("R8", "zero", {31'd0, zero}, {31'd0, (m[W-1:0] == '0)});
            check((VECS[i].exp_ctl == 4'b0010 || VECS[i].exp_ctl == 4'b0110) ? "R9" : "R10",
                  "overflow", {31'd0, overflow}, {31'd0, m[W]});
        end

        // Directed corners
        apply(2'b00, 6'h20, 32'hFFFF_FFFF, 32'd1, 1'b0);
        check("R4", "wrap sum", result, 32'd0);
        check("R9", "carry-out without overflow", {31'd0, overflow}, 32'd0);

        apply(2'b01, 6'h00, 32'd0, 32'd1, 1'b0);
        check("R5", "0-1", result, 32'hFFFF_FFFF);

        apply(2'b10, 6'h2A, 32'h8000_0000, 32'h7FFF_FFFF, 1'b0);
        check("R6", "wrapped diff sign", result, 32'd0);
        check("R10", "slt no overflow", {31'd0, overflow}, 32'd0);

        apply(2'b11, 6'h0F, 32'h1234_5678, 32'h1234_5678, 1'b0);
        check("R3", "reserved 1111 result", result, 32'd0);
        check("R11", "direct 1111 ctl", {28'd0, alu_ctl}, 32'd15);

        apply(2'b10, 6'h00, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0);
        check("R3", "funct 0 under class 10", {28'd0, alu_ctl}, 32'd15);
        check("R3", "funct 0 overflow", {31'd0, overflow}, 32'd0);

        apply(2'b11, 6'h0C, 32'd0, 32'd0, 1'b0);
        check("R7", "nor of zeros", result, 32'hFFFF_FFFF);

        finish_run();
    end
endmodule